// File: doc/BRIEF.md
# Transmit Loopback Word Checker

This block runs the on-line loop test of a serial-bus remote terminal. Whenever the terminal's encoder sends a word, the checker keeps a copy of it. The terminal's own bus receiver then decodes the same word back off the bus, and the checker judges that echo. The echo must carry no sync, Manchester or bit-count error, and its parity must be correct. When the transmitted word is the final word of the message, the echo must also match it exactly: all sixteen data bits and the sync type.

Any failure produces a one-cycle loop-fail strobe, which the surrounding status logic uses to raise its terminal-fail flag. An echo that never arrives within a fixed window also counts as a failure. The checker holds one outstanding word at a time and is cleared at the start of each message. A broadcast flag, captured together with the message-start strobe, mutes every failure report for that message.

Top module: `loopback_word_checker`

## Requirements
- R1: After a synchronous reset, `loop_fail` is 0 and no transmitted word is pending.
- R2: An echo of a pending word that arrives with any of `rx_sync_err`, `rx_manch_err` or `rx_bitcnt_err` set is a failure.
- R3: Parity is odd. The 16 bits of `rx_data` together with `rx_parity` must contain an odd number of ones, or the echo is a failure.
- R4: For a pending word with `tx_last`=0, the echo is judged only on the checks of R2 and R3. A data difference from the transmitted word is not a failure.
- R5: For a pending word with `tx_last`=1, the echo must equal the transmitted word in all 16 data bits and in the sync type (`rx_cmd_sync` = `tx_cmd_sync`, 1 = command/status sync, 0 = data sync). Any difference is a failure.
- R6: Take a word captured on clock edge k. An echo sampled on any edge from k+1 to k+TIMEOUT is accepted and judged. If no echo has been sampled by edge k+TIMEOUT, that edge records a missing-echo failure and drops the pending word.
- R7: A new `tx_valid` while a word is still pending, with no echo on the same edge, is a missing-echo failure for the old word. The new word becomes the pending word, and its window starts from that edge.
- R8: `msg_bcast` is sampled on the edge where `msg_start` is 1. While the sampled value is 1, no failure of that message produces a `loop_fail` pulse.
- R9: `msg_start` drops any pending word without a failure and restarts the window. A `tx_valid` or `rx_valid` on the same edge is ignored.
- R10: An `rx_valid` while no word is pending is ignored and never produces a failure.
- R11: `loop_fail` is high for the one cycle after the edge that recorded a failure. A clean echo produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_start | input | 1 | Start-of-message strobe; clears the checker |
| msg_bcast | input | 1 | Broadcast flag, sampled with `msg_start` |
| tx_valid | input | 1 | Transmitted-word strobe |
| tx_data | input | 16 | Transmitted data bits |
| tx_cmd_sync | input | 1 | Transmitted sync type (1 command/status, 0 data) |
| tx_last | input | 1 | Marks the final word of the message |
| rx_valid | input | 1 | Decoded-echo strobe |
| rx_data | input | 16 | Decoded data bits |
| rx_cmd_sync | input | 1 | Decoded sync type |
| rx_parity | input | 1 | Decoded parity bit |
| rx_sync_err | input | 1 | Decoder found an invalid sync pattern |
| rx_manch_err | input | 1 | Decoder found a Manchester coding violation |
| rx_bitcnt_err | input | 1 | Decoder found a wrong bit count |
| loop_fail | output | 1 | One-cycle loop-test failure strobe |

## Verification
Assertions check five properties on every cycle:
- the output is quiet right after reset;
- broadcast messages never pulse;
- a message start clears the pending word and silences the next cycle;
- an expired window drops the pending word;
- an echo with nothing pending never fails.

The directed scenarios show the judging itself: each decoder error flag, wrong parity, and the exact compare that applies only to a final word. They also cover the window edges: an echo on the last accepted edge, and a timeout on exactly that edge. Replacement of an unechoed word and tolerance of data differences on non-final words also need these scenarios.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    localparam int unsigned WORD_W = 16;

    // A transmitted word as held while its echo is awaited
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              cmd_sync;
        logic              last;
    } tx_word_t;

    // A decoded echo with the decoder's error flags
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              cmd_sync;
        logic              parity;
        logic              sync_err;
        logic              manch_err;
        logic              bitcnt_err;
    } rx_word_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_LINE    = 2'd1,
        CAUSE_PARITY  = 2'd2,
        CAUSE_COMPARE = 2'd3
    } fail_cause_t;

    // Odd parity: data plus parity bit hold an odd number of ones
    function automatic logic parity_is_odd(logic [WORD_W-1:0] d, logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/lbk_pending.sv
module lbk_pending
    import lbk_pkg::*;
#(
    parameter int unsigned TIMEOUT = 24
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     load,
    input  tx_word_t load_word,
    input  logic     consume,
    output logic     pend_q,
    output tx_word_t word_q,
    output logic     timeout_evt,
    output logic     displace_evt
);
    localparam int unsigned CNT_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign timeout_evt  = pend_q && !consume && !load && (cnt_q == LIMIT);
    assign displace_evt = pend_q && !consume && load;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            word_q <= '0;
        end else if (load) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
            word_q <= load_word;
        end else if (consume || timeout_evt) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pend_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R6: an expired window drops the pending word
    p_window_expiry_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !consume && !load && !clr && cnt_q == LIMIT) |=> !pend_q)
        else $error("window expiry did not drop pending word");

    // R7: a load always leaves a fresh pending word with a restarted window
    p_load_restarts_r7: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (pend_q && cnt_q == '0))
        else $error("load did not restart window");

endmodule

// File: rtl/lbk_echo_judge.sv
module lbk_echo_judge
    import lbk_pkg::*;
(
    input  tx_word_t    sent,
    input  rx_word_t    echo,
    output fail_cause_t cause
);
    logic line_bad;
    logic par_bad;
    logic cmp_bad;

    assign line_bad = echo.sync_err | echo.manch_err | echo.bitcnt_err;
    assign par_bad  = !parity_is_odd(echo.data, echo.parity);
    assign cmp_bad  = sent.last &&
                      ((echo.data != sent.data) || (echo.cmd_sync != sent.cmd_sync));

    always_comb begin
        if (line_bad)      cause = CAUSE_LINE;
        else if (par_bad)  cause = CAUSE_PARITY;
        else if (cmp_bad)  cause = CAUSE_COMPARE;
        else               cause = CAUSE_NONE;
    end

endmodule

// File: rtl/loopback_word_checker.sv
module loopback_word_checker
    import lbk_pkg::*;
#(
    parameter int unsigned TIMEOUT = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_start,
    input  logic              msg_bcast,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_cmd_sync,
    input  logic              tx_last,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_cmd_sync,
    input  logic              rx_parity,
    input  logic              rx_sync_err,
    input  logic              rx_manch_err,
    input  logic              rx_bitcnt_err,
    output logic              loop_fail
);
    tx_word_t    tx_word;
    rx_word_t    rx_word;
    tx_word_t    held_word;
    fail_cause_t cause;
    logic        pend_q;
    logic        load;
    logic        consume;
    logic        timeout_evt;
    logic        displace_evt;
    logic        fail_evt;
    logic        bcast_q;

    assign tx_word = '{data: tx_data, cmd_sync: tx_cmd_sync, last: tx_last};
    assign rx_word = '{data: rx_data, cmd_sync: rx_cmd_sync, parity: rx_parity,
                       sync_err: rx_sync_err, manch_err: rx_manch_err,
                       bitcnt_err: rx_bitcnt_err};

    assign load    = tx_valid && !msg_start;
    assign consume = rx_valid && pend_q && !msg_start;

    lbk_pending #(.TIMEOUT(TIMEOUT)) pending_i (
        .clk          (clk),
        .rst          (rst),
        .clr          (msg_start),
        .load         (load),
        .load_word    (tx_word),
        .consume      (consume),
        .pend_q       (pend_q),
        .word_q       (held_word),
        .timeout_evt  (timeout_evt),
        .displace_evt (displace_evt)
    );

    lbk_echo_judge judge_i (
        .sent  (held_word),
        .echo  (rx_word),
        .cause (cause)
    );

    assign fail_evt = !msg_start &&
                      ((consume && cause != CAUSE_NONE) || timeout_evt || displace_evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            bcast_q   <= 1'b0;
            loop_fail <= 1'b0;
        end else begin
            if (msg_start) bcast_q <= msg_bcast;
            loop_fail <= fail_evt && !bcast_q;
        end
    end

    // R1: the output is quiet in the first cycle out of reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !loop_fail)
        else $error("loop_fail after reset");

    // R8: a broadcast message never pulses
    p_bcast_silent_r8: assert property (@(posedge clk) disable iff (rst)
        $past(bcast_q) |-> !loop_fail)
        else $error("loop_fail during broadcast");

    // R9: message start clears the pending word and produces no pulse
    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        msg_start |=> (!pend_q && !loop_fail))
        else $error("message start did not clear");

    // R10: an echo with nothing pending never fails
    p_unsolicited_echo_r10: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !tx_valid) |=> !loop_fail)
        else $error("failure with nothing pending");

endmodule

// File: tb/loopback_word_checker_tb_top.sv
module loopback_word_checker_tb_top;
    localparam int TO = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_start = 0, msg_bcast = 0;
    logic        tx_valid = 0, tx_cmd_sync = 0, tx_last = 0;
    logic [15:0] tx_data = '0;
    logic        rx_valid = 0, rx_cmd_sync = 0, rx_parity = 0;
    logic [15:0] rx_data = '0;
    logic        rx_sync_err = 0, rx_manch_err = 0, rx_bitcnt_err = 0;
    logic        loop_fail;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    loopback_word_checker #(.TIMEOUT(TO)) dut_i (
        .clk(clk), .rst(rst), .msg_start(msg_start), .msg_bcast(msg_bcast),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_cmd_sync(tx_cmd_sync),
        .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_cmd_sync(rx_cmd_sync), .rx_parity(rx_parity),
        .rx_sync_err(rx_sync_err), .rx_manch_err(rx_manch_err),
        .rx_bitcnt_err(rx_bitcnt_err), .loop_fail(loop_fail)
    );

    function automatic logic good_par(input logic [15:0] d);
        return ~^d;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: loop_fail=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Apply the current drives across one edge, then sample and release strobes
    task automatic step(output logic lf);
        @(posedge clk);
        #1;
        lf = loop_fail;
        msg_start = 0; tx_valid = 0; rx_valid = 0;
        rx_sync_err = 0; rx_manch_err = 0; rx_bitcnt_err = 0;
    endtask

    task automatic start_msg(input logic b);
        logic lf;
        msg_start = 1; msg_bcast = b;
        step(lf);
        msg_bcast = 0;
    endtask

    task automatic send(input logic [15:0] d, input logic cmd, input logic last,
                        output logic lf);
        tx_valid = 1; tx_data = d; tx_cmd_sync = cmd; tx_last = last;
        step(lf);
    endtask

    task automatic echo(input logic [15:0] d, input logic cmd, input logic par,
                        input logic se, input logic me, input logic be,
                        output logic lf);
        rx_valid = 1; rx_data = d; rx_cmd_sync = cmd; rx_parity = par;
        rx_sync_err = se; rx_manch_err = me; rx_bitcnt_err = be;
        step(lf);
    endtask

    task automatic idle(input int n, input string tag, input logic exp_last);
        logic lf;
        for (int i = 1; i <= n; i++) begin
            step(lf);
            check(tag, lf, (i == n) ? exp_last : 1'b0);
        end
    endtask

    task automatic t_reset();
        logic lf;
        step(lf);
        check("R1 reset state", lf, 1'b0);
    endtask

    task automatic t_clean();
        logic lf;
        start_msg(0);
        send(16'h1234, 1, 0, lf);
        echo(16'h1234, 1, good_par(16'h1234), 0, 0, 0, lf);
        check("R11 clean non-last echo", lf, 1'b0);
        send(16'hABCD, 0, 1, lf);
        echo(16'hABCD, 0, good_par(16'hABCD), 0, 0, 0, lf);
        check("R11 clean last echo", lf, 1'b0);
    endtask

    task automatic t_nonlast_diff();
        logic lf;
        start_msg(0);
        send(16'h00FF, 0, 0, lf);
        echo(16'h0F0E, 1, good_par(16'h0F0E), 0, 0, 0, lf);
        check("R4 non-last data difference", lf, 1'b0);
    endtask

    task automatic t_flags();
        logic lf;
        start_msg(0);
        send(16'h2222, 0, 0, lf);
        echo(16'h2222, 0, good_par(16'h2222), 1, 0, 0, lf);
        check("R2 sync error", lf, 1'b1);
        step(lf);
        check("R11 single-cycle pulse", lf, 1'b0);
        send(16'h3333, 0, 0, lf);
        echo(16'h3333, 0, good_par(16'h3333), 0, 1, 0, lf);
        check("R2 manchester error", lf, 1'b1);
        send(16'h4444, 0, 0, lf);
        echo(16'h4444, 0, good_par(16'h4444), 0, 0, 1, lf);
        check("R2 bit-count error", lf, 1'b1);
    endtask

    task automatic t_parity();
        logic lf;
        start_msg(0);
        send(16'h0001, 0, 0, lf);
        echo(16'h0001, 0, ~good_par(16'h0001), 0, 0, 0, lf);
        check("R3 even parity rejected", lf, 1'b1);
        send(16'h0003, 0, 0, lf);
        echo(16'h0003, 0, 1'b1, 0, 0, 0, lf);
        check("R3 odd parity accepted", lf, 1'b0);
    endtask

    task automatic t_last();
        logic lf;
        start_msg(0);
        send(16'h5555, 0, 1, lf);
        echo(16'h5554, 0, good_par(16'h5554), 0, 0, 0, lf);
        check("R5 last data mismatch", lf, 1'b1);
        send(16'h8001, 1, 1, lf);
        echo(16'h8001, 0, good_par(16'h8001), 0, 0, 0, lf);
        check("R5 last sync-type mismatch", lf, 1'b1);
    endtask

    task automatic t_timeout();
        logic lf;
        start_msg(0);
        send(16'h6666, 0, 0, lf);
        idle(TO, "R6 timeout on last window edge", 1'b1);
        send(16'h7777, 0, 0, lf);
        idle(TO - 1, "R6 quiet inside window", 1'b0);
        echo(16'h7777, 0, good_par(16'h7777), 0, 0, 0, lf);
        check("R6 echo on last window edge accepted", lf, 1'b0);
        idle(TO + 2, "R6 no timeout after echo", 1'b0);
    endtask

    task automatic t_displace();
        logic lf;
        start_msg(0);
        send(16'h1111, 0, 0, lf);
        send(16'h2468, 0, 0, lf);
        check("R7 unechoed word displaced", lf, 1'b1);
        echo(16'h2468, 0, good_par(16'h2468), 0, 0, 0, lf);
        check("R7 new word echo clean", lf, 1'b0);
    endtask

    task automatic t_bcast();
        logic lf;
        start_msg(1);
        send(16'h1357, 0, 0, lf);
        echo(16'h1357, 0, good_par(16'h1357), 1, 0, 0, lf);
        check("R8 broadcast error muted", lf, 1'b0);
        send(16'h1357, 0, 0, lf);
        idle(TO + 1, "R8 broadcast timeout muted", 1'b0);
        start_msg(0);
        send(16'h1357, 0, 0, lf);
        echo(16'h1357, 0, good_par(16'h1357), 1, 0, 0, lf);
        check("R8 non-broadcast error reported", lf, 1'b1);
    endtask

    task automatic t_clear();
        logic lf;
        start_msg(0);
        send(16'h9999, 0, 0, lf);
        msg_start = 1;
        rx_valid = 1; rx_data = 16'h0000; rx_parity = 0; rx_sync_err = 1;
        step(lf);
        check("R9 start drops pending and echo", lf, 1'b0);
        idle(TO + 2, "R9 no timeout after clear", 1'b0);
        msg_start = 1; tx_valid = 1; tx_data = 16'hAAAA;
        step(lf);
        idle(TO + 2, "R9 tx with start ignored", 1'b0);
    endtask

    task automatic t_unsolicited();
        logic lf;
        start_msg(0);
        echo(16'h0000, 1, 1'b0, 1, 1, 1, lf);
        check("R10 echo with nothing pending", lf, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_clean();
        t_nonlast_diff();
        t_flags();
        t_parity();
        t_last();
        t_timeout();
        t_displace();
        t_bcast();
        t_clear();
        t_unsolicited();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule